// File: doc/BRIEF.md
# SPI Serial EEPROM Slave (1K x 8)

This block is the serial side of a small byte-addressed nonvolatile memory of 1024 bytes. It sits behind the four SPI pins (active-low select, serial clock, serial in, serial out) and an active-low pause input. The pins are oversampled by the chip's own system clock. Every transaction starts on a falling edge of select. The first byte shifted in is an 8-bit opcode, and it chooses one of these operations: write-enable set or clear, status read, status write, sequential read, or page write.

Write data is collected in a 32-byte page buffer. It is committed to the array only after select rises, by an internal program cycle that lasts a parameterised number of system clocks. While that cycle runs, only the status read is honoured. A write-enable latch gates every write. It is cleared at reset and again at the end of each program cycle. Two status bits choose how much of the upper part of the array is locked against writes.

The serial output is presented to the pad ring as a data bit and an output enable. When the enable is low, the pad is high-impedance.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output enable is low. The array reads 0xFF everywhere (erased).
- R2: All bits move most significant bit first, with SPI mode 0 timing: input is sampled on SCK rising and output changes on SCK falling. The opcodes are 0x01 status write, 0x02 page write, 0x03 read, 0x04 write disable, 0x05 status read and 0x06 write enable.
- R3: A page write or status write received while the write-enable latch (status bit 1) is clear is ignored. Memory is unchanged and no program cycle starts.
- R4: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Each takes effect only if select rises after exactly 8 bits. A frame with any extra bit has no effect.
- R5: Select rising after at least one whole write-data byte starts a program cycle of WR_CYCLES clocks, shown in status bit 0. At the end of the cycle the data is in memory and the write-enable latch is clear.
- R6: A read is the opcode, then two address bytes (high byte first, only the low 10 bits used), then data on SO. The address increments after every byte and wraps from 0x3FF to 0x000.
- R7: A page write keeps the upper 5 address bits fixed and increments the lower 5 bits with wrap. More than 32 bytes overwrite bytes loaded earlier in the same frame.
- R8: During a program cycle every opcode except 0x05 is ignored, and a read attempted then never enables SO.
- R9: The SO enable is low during opcode, address and write-data input, and whenever select is high.
- R10: While HOLD is low, SCK edges are ignored and SO is disabled. The transfer resumes where it stopped when HOLD goes high.
- R11: Status bits 3:2 select the protected range: 0 protects none, 1 protects 0x300-0x3FF, 2 protects 0x200-0x3FF, 3 protects all. A page write into a protected page leaves memory unchanged.
- R12: A status write with the latch set loads data bits 3:2 into the protect bits when its program cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause of serial shifting |
| so_d | output | 1 | Serial data out, valid when so_oe is high |
| so_oe | output | 1 | Output enable for the SO pad; low means high-impedance |

## Verification
The main function, page programming followed by read-back, is exercised with a table that pairs each protect level with addresses just inside and just outside its locked range. A boundary error in the range decode therefore shows up as a wrong byte. Separate patterns cover a single byte, a 34-byte burst that must wrap and overwrite the start of its page, and a short write that starts two bytes before a page end. These patterns separate page-offset wrap from full-address increment. Reads that cross a page boundary and the top of the array separate the 10-bit read increment from the 5-bit write increment. A transfer paused by HOLD in mid-byte, and frames with one byte too many, check that the shifting state survives a pause and that a command counts only when its frame ends on a byte boundary.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [3:0] {
    ST_SINK,
    ST_OPC,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA,
    ST_STAT,
    ST_SRDATA,
    ST_CMD
  } ctl_state_t;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // quad is the top two address bits of the target page
  function automatic logic region_locked(input logic [1:0] lvl, input logic [1:0] quad);
    case (lvl)
      2'd0:    region_locked = 1'b0;
      2'd1:    region_locked = (quad == 2'd3);
      2'd2:    region_locked = quad[1];
      default: region_locked = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold_act
);
  localparam logic [3:0] IDLE_PINS = 4'b1001; // {hold_n, si, sck, cs_n}

  logic [3:0] pipe [SYNC_N];
  logic [3:0] pins;
  logic       cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_N; k++) pipe[k] <= IDLE_PINS;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      pipe[0] <= {hold_n, si, sck, cs_n};
      for (int k = 1; k < SYNC_N; k++) pipe[k] <= pipe[k-1];
      cs_d  <= pipe[SYNC_N-1][0];
      sck_d <= pipe[SYNC_N-1][1];
    end
  end

  assign pins     = pipe[SYNC_N-1];
  assign sel      = ~pins[0];
  assign hold_act = ~pins[3];
  assign si_s     = pins[2];
  assign cs_fall  = cs_d & ~pins[0];
  assign cs_rise  = ~cs_d & pins[0];
  assign sck_rise = sel & ~hold_act & pins[1] & ~sck_d;
  assign sck_fall = sel & ~hold_act & ~pins[1] & sck_d;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              hold_act,
  input  logic              busy,
  input  logic              wc_done,
  input  logic [1:0]        bp,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              so_bit,
  output logic              out_on,
  output logic              wel,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_idx,
  output logic [7:0]        buf_data,
  output logic              pg_start,
  output logic [PG_W-1:0]   pg_page,
  output logic              sr_start,
  output logic [1:0]        sr_bp
);
  ctl_state_t        state;
  logic [2:0]        bit_cnt, out_cnt;
  logic [6:0]        in_sr;
  logic [7:0]        opc, out_sr, byte_now, stat_byte, src;
  logic [ADDR_W-1:0] addr;
  logic              data_seen;

  assign byte_now  = {in_sr, si_s};
  assign stat_byte = {4'b0000, bp, wel, busy};
  assign src       = (state == ST_RDATA) ? rd_byte : stat_byte;
  assign rd_addr   = addr;
  assign pg_page   = addr[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SINK;
      bit_cnt   <= '0;
      out_cnt   <= '0;
      in_sr     <= '0;
      opc       <= '0;
      out_sr    <= '0;
      addr      <= '0;
      data_seen <= 1'b0;
      so_bit    <= 1'b0;
      out_on    <= 1'b0;
      wel       <= 1'b0;
      buf_clr   <= 1'b0;
      buf_we    <= 1'b0;
      buf_idx   <= '0;
      buf_data  <= '0;
      pg_start  <= 1'b0;
      sr_start  <= 1'b0;
      sr_bp     <= '0;
    end else begin
      buf_clr  <= 1'b0;
      buf_we   <= 1'b0;
      pg_start <= 1'b0;
      sr_start <= 1'b0;
      if (wc_done) wel <= 1'b0;

      if (cs_fall) begin
        state     <= ST_OPC;
        bit_cnt   <= '0;
        out_cnt   <= '0;
        out_on    <= 1'b0;
        data_seen <= 1'b0;
      end else if (cs_rise) begin
        out_on <= 1'b0;
        if (bit_cnt == 3'd0) begin
          case (state)
            ST_CMD: begin
              if (opc == OP_WREN) wel <= 1'b1;
              else                wel <= 1'b0;
            end
            ST_WDATA:  if (data_seen) pg_start <= 1'b1;
            ST_SRDATA: if (data_seen) sr_start <= 1'b1;
            default: ;
          endcase
        end
        state <= ST_SINK;
      end else begin
        if (sck_rise) begin
          in_sr   <= byte_now[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (state == ST_CMD) state <= ST_SINK;
          if (bit_cnt == 3'd7) begin
            case (state)
              ST_OPC: begin
                opc <= byte_now;
                if (busy && byte_now != OP_RDSR) state <= ST_SINK;
                else begin
                  case (byte_now)
                    OP_READ:  state <= ST_ADDR_HI;
                    OP_RDSR:  state <= ST_STAT;
                    OP_WREN,
                    OP_WRDI:  state <= ST_CMD;
                    OP_WRITE: begin
                      state   <= wel ? ST_ADDR_HI : ST_SINK;
                      buf_clr <= wel;
                    end
                    OP_WRSR:  state <= wel ? ST_SRDATA : ST_SINK;
                    default:  state <= ST_SINK;
                  endcase
                end
              end
              ST_ADDR_HI: begin
                addr[ADDR_W-1:8] <= byte_now[ADDR_W-9:0];
                state <= ST_ADDR_LO;
              end
              ST_ADDR_LO: begin
                addr[7:0] <= byte_now;
                state <= (opc == OP_READ) ? ST_RDATA : ST_WDATA;
              end
              ST_WDATA: begin
                buf_we    <= 1'b1;
                buf_idx   <= addr[PAGE_W-1:0];
                buf_data  <= byte_now;
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                data_seen <= 1'b1;
              end
              ST_SRDATA: begin
                if (!data_seen) begin
                  sr_bp     <= byte_now[3:2];
                  data_seen <= 1'b1;
                end else begin
                  data_seen <= 1'b0;
                  state     <= ST_SINK;
                end
              end
              default: ;
            endcase
          end
        end
        if (sck_fall && (state == ST_RDATA || state == ST_STAT)) begin
          if (out_cnt == 3'd0) begin
            so_bit <= src[7];
            out_sr <= {src[6:0], 1'b0};
            if (state == ST_RDATA) addr <= addr + 1'b1;
          end else begin
            so_bit <= out_sr[7];
            out_sr <= {out_sr[6:0], 1'b0};
          end
          out_cnt <= out_cnt + 3'd1;
          out_on  <= 1'b1;
        end
      end
    end
  end

  // R5: the latch is clear the cycle after a program cycle finishes
  p_wel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wc_done |=> !wel);

  // R8: a non-status opcode finishing while busy is dropped
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_fall && !cs_rise && bit_cnt == 3'd7 && state == ST_OPC &&
     busy && byte_now != OP_RDSR) |=> state == ST_SINK);

  // R10: no bit is counted while the pause input is active
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_fall && !cs_rise) |=> $stable(bit_cnt));

endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000,
  localparam int PG_W     = ADDR_W - PAGE_W,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int PBYTES   = 1 << PAGE_W,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_data,
  input  logic              pg_start,
  input  logic [PG_W-1:0]   pg_page,
  input  logic              sr_start,
  input  logic [1:0]        sr_bp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              busy,
  output logic              wc_done,
  output logic [1:0]        bp
);
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PBYTES];
  logic [PBYTES-1:0] mask;
  logic [PG_W-1:0]   page_q;
  logic [1:0]        bp_next;
  logic              kind_pg;
  logic [CNT_W-1:0]  cnt;

  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PBYTES; i++) pbuf[i] <= 8'h00;
      mask    <= '0;
      page_q  <= '0;
      bp_next <= '0;
      bp      <= '0;
      kind_pg <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      wc_done <= 1'b0;
    end else begin
      wc_done <= 1'b0;
      if (buf_clr) mask <= '0;
      if (buf_we) begin
        pbuf[buf_idx] <= buf_data;
        mask[buf_idx] <= 1'b1;
      end
      if (!busy) begin
        if (pg_start && !region_locked(bp, pg_page[PG_W-1 -: 2])) begin
          busy    <= 1'b1;
          kind_pg <= 1'b1;
          page_q  <= pg_page;
          cnt     <= CNT_W'(WR_CYCLES - 1);
        end else if (sr_start) begin
          busy    <= 1'b1;
          kind_pg <= 1'b0;
          bp_next <= sr_bp;
          cnt     <= CNT_W'(WR_CYCLES - 1);
        end
      end else if (cnt == '0) begin
        busy    <= 1'b0;
        wc_done <= 1'b1;
        if (kind_pg) begin
          for (int i = 0; i < PBYTES; i++)
            if (mask[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
        end else begin
          bp <= bp_next;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R5: busy stays high for exactly WR_CYCLES clocks, measured independently
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else        busy_len <= busy ? busy_len + 1 : 0;
  end

  p_cycle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WR_CYCLES);

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000,
  parameter int SYNC_N    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so_d,
  output logic so_oe
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic              sel, cs_fall, cs_rise, sck_rise, sck_fall, si_s, hold_act;
  logic              busy, wc_done, wel, out_on, so_bit;
  logic              buf_clr, buf_we, pg_start, sr_start;
  logic [1:0]        bp, sr_bp;
  logic [7:0]        rd_byte, buf_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [PAGE_W-1:0] buf_idx;
  logic [PG_W-1:0]   pg_page;

  spi_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act)
  );

  spi_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act),
    .busy(busy), .wc_done(wc_done), .bp(bp), .rd_byte(rd_byte),
    .rd_addr(rd_addr), .so_bit(so_bit), .out_on(out_on), .wel(wel),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .pg_start(pg_start), .pg_page(pg_page), .sr_start(sr_start), .sr_bp(sr_bp)
  );

  spi_prog_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .pg_start(pg_start),
    .pg_page(pg_page), .sr_start(sr_start), .sr_bp(sr_bp), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .busy(busy), .wc_done(wc_done), .bp(bp)
  );

  assign so_d  = so_bit;
  assign so_oe = out_on & sel & ~hold_act;

  // R5: a program cycle only begins right after a commit request
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pg_start || sr_start));

  // R11: a commit into a locked page never raises busy
  p_locked_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_start && !busy && region_locked(bp, pg_page[PG_W-1 -: 2])) |=> !busy);

endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int HALF = 8;
  localparam int WRC  = 600;
  // {protect level[1:0], address[9:0], data[7:0], expect programmed}
  localparam logic [20:0] VEC [8] = '{
    {2'd0, 10'h005, 8'h3C, 1'b1},
    {2'd0, 10'h3FF, 8'hA5, 1'b1},
    {2'd1, 10'h300, 8'h11, 1'b0},
    {2'd1, 10'h2FF, 8'h22, 1'b1},
    {2'd2, 10'h200, 8'h33, 1'b0},
    {2'd2, 10'h1FF, 8'h44, 1'b1},
    {2'd3, 10'h000, 8'h55, 1'b0},
    {2'd3, 10'h100, 8'h66, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so_d, so_oe;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;
  logic [7:0] wbuf [40];
  logic [7:0] rbuf [40];

  always #5 clk = ~clk;

  spi_eeprom_slave #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so_d(so_d), .so_oe(so_oe)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    r  = so_d;
    oe = so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    rx = '0;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic r, o;
      bit_x(tx[i], r, o);
      rx[i] = r;
      oe_any |= o;
    end
  endtask

  task automatic cs_low;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d; logic o;
    cs_low(); byte_x(op, d, o); cs_high();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d; logic o;
    cs_low(); byte_x(8'h05, d, o); byte_x(8'h00, st, o); cs_high();
  endtask

  task automatic wait_ready;
    logic [7:0] st;
    for (int k = 0; k < 60; k++) begin
      rdsr(st);
      if (!st[0]) return;
    end
    checks++; errors++;
    $display("FAIL R5: busy never cleared, actual %h expected 00", st);
  endtask

  task automatic wr(input logic [9:0] a, input int n);
    logic [7:0] d; logic o;
    cs_low();
    byte_x(8'h02, d, o);
    byte_x({6'b0, a[9:8]}, d, o);
    byte_x(a[7:0], d, o);
    for (int i = 0; i < n; i++) byte_x(wbuf[i], d, o);
    cs_high();
  endtask

  task automatic rd(input logic [15:0] a, input int n, output logic hdr_oe, output logic dat_oe);
    logic [7:0] d; logic o1, o2, o3, od;
    cs_low();
    byte_x(8'h03, d, o1);
    byte_x(a[15:8], d, o2);
    byte_x(a[7:0], d, o3);
    hdr_oe = o1 | o2 | o3;
    dat_oe = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, rbuf[i], od);
      dat_oe |= od;
    end
    cs_high();
  endtask

  task automatic set_bp(input logic [1:0] lvl);
    logic [7:0] d; logic o;
    cmd(8'h06);
    cs_low(); byte_x(8'h01, d, o); byte_x({4'b0, lvl, 2'b0}, d, o); cs_high();
    wait_ready();
  endtask

  initial begin
    logic [7:0] st, rx;
    logic ho, dox, r, o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R9: idle output and reset status
    check8("R1 so_oe after reset", {7'b0, so_oe}, 8'h00);
    rdsr(st);
    check8("R1 status after reset", st, 8'h00);

    // R4: latch set/clear and extra-bit frames
    cmd(8'h06); rdsr(st);
    check8("R4 WREN sets latch", st, 8'h02);
    cmd(8'h04); rdsr(st);
    check8("R4 WRDI clears latch", st, 8'h00);
    cs_low(); byte_x(8'h06, rx, o); byte_x(8'h00, rx, o); cs_high();
    rdsr(st);
    check8("R4 WREN with extra byte ignored", st, 8'h00);

    // R3: write without the latch
    wbuf[0] = 8'h12;
    wr(10'h040, 1);
    rdsr(st);
    check8("R3 no cycle without latch", st, 8'h00);
    rd(16'h0040, 1, ho, dox);
    check8("R3 memory unchanged", rbuf[0], 8'hFF);

    // R11 / R12: table of protect level vs target address
    for (int v = 0; v < 8; v++) begin
      logic [20:0] e;
      e = VEC[v];
      set_bp(e[20:19]);
      rdsr(st);
      check8($sformatf("R12 protect bits vector %0d", v), st, {4'b0, e[20:19], 2'b0});
      cmd(8'h06);
      wbuf[0] = e[8:1];
      wr(e[18:9], 1);
      wait_ready();
      rd({6'b0, e[18:9]}, 1, ho, dox);
      check8($sformatf("R11 read-back vector %0d", v), rbuf[0], e[0] ? e[8:1] : 8'hFF);
    end
    set_bp(2'd0);
    rdsr(st);
    check8("R12 protect cleared", st, 8'h00);

    // R5 / R8: program cycle and busy behaviour
    cmd(8'h06);
    wbuf[0] = 8'h9A;
    wr(10'h080, 1);
    rdsr(st);
    check8("R5 busy and latch during cycle", st, 8'h03);
    rd(16'h0080, 1, ho, dox);
    check8("R8 read ignored while busy", {7'b0, dox}, 8'h00);
    wait_ready();
    rdsr(st);
    check8("R5 latch cleared after cycle", st, 8'h00);
    rd(16'h0080, 1, ho, dox);
    check8("R5 data programmed", rbuf[0], 8'h9A);
    check8("R9 header not driven", {7'b0, ho}, 8'h00);
    check8("R2 data driven", {7'b0, dox}, 8'h01);

    // R7: 34-byte burst wraps within page 0x0A0
    cmd(8'h06);
    for (int i = 0; i < 34; i++) wbuf[i] = 8'h10 + 8'(i);
    wr(10'h0A0, 34);
    wait_ready();
    rd(16'h00A0, 33, ho, dox);
    check8("R7 offset 0 overwritten", rbuf[0], 8'h30);
    check8("R7 offset 1 overwritten", rbuf[1], 8'h31);
    check8("R7 offset 5", rbuf[5], 8'h15);
    check8("R7 offset 31", rbuf[31], 8'h2F);
    check8("R6 read crosses page", rbuf[32], 8'hFF);

    // R7: start near page end
    cmd(8'h06);
    wbuf[0] = 8'h77; wbuf[1] = 8'h88; wbuf[2] = 8'h99;
    wr(10'h0FE, 3);
    wait_ready();
    rd(16'h00E0, 1, ho, dox);
    check8("R7 wrap to page start", rbuf[0], 8'h99);
    rd(16'h00FE, 3, ho, dox);
    check8("R6 seq byte 0", rbuf[0], 8'h77);
    check8("R6 seq byte 1", rbuf[1], 8'h88);
    check8("R6 seq into next page", rbuf[2], 8'hFF);

    // R6: top wrap and ignored upper address bits
    rd(16'h03FF, 2, ho, dox);
    check8("R6 top byte", rbuf[0], 8'hA5);
    check8("R6 wrap to 0", rbuf[1], 8'hFF);
    rd(16'hFC05, 1, ho, dox);
    check8("R6 upper bits ignored", rbuf[0], 8'h3C);

    // R10: pause in mid-byte
    cs_low();
    byte_x(8'h03, rx, o); byte_x(8'h00, rx, o); byte_x(8'h05, rx, o);
    rx = '0;
    for (int i = 7; i >= 4; i--) begin bit_x(1'b0, r, o); rx[i] = r; end
    @(negedge clk) hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check8("R10 SO off during hold", {7'b0, so_oe}, 8'h00);
    for (int t = 0; t < 2; t++) begin
      sck = 1'b1; si = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 3; i >= 0; i--) begin bit_x(1'b0, r, o); rx[i] = r; end
    cs_high();
    check8("R10 byte intact across hold", rx, 8'h3C);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule